// File: doc/BRIEF.md
# Self-Checking Response Signature Register

This block sits at the scan-out side of a test structure. It folds every valid response word into a short signature held in a multiple-input signature register, and keeps no raw responses. When the test controller strobes end-of-test, the block compares the signature with an expected value programmed on its inputs. It then reports the result on one pass/fail pin, next to a done flag.

A clear pulse opens a session: the register returns to a fixed non-zero seed and any earlier verdict is dropped. Response words are accepted only in cycles where their valid strobe is high. The verdict is taken once and held, so the tester only needs to watch a single pin after the session ends.

Top module: `sig_check_unit`

## Requirements
- R1: An accepted word D updates the signature S (width 16 by default) as S' = (S shifted left by one, bit 0 cleared) XOR (0x002D if bit 15 of S was 1, else 0) XOR D. This is a Galois register for x^16+x^5+x^3+x^2+1.
- R2: A cycle with clear_i high loads the seed 0xACE1 and forces done_o and pass_o low on the next edge. This takes priority over resp_valid_i and end_i in the same cycle.
- R3: In a cycle with resp_valid_i low and clear_i low, the signature keeps its value whatever resp_data_i carries.
- R4: When end_i is high, clear_i is low and done_o is low, done_o goes high on the next edge. pass_o goes high on that edge only if the signature of the words accepted in earlier cycles equals golden_i in the end cycle. A word accepted in the end cycle itself is not part of that compare.
- R5: While done_o is high, further end_i strobes, response words and golden_i changes leave done_o and pass_o unchanged until a clear.
- R6: pass_o is low in every cycle in which done_o is low.
- R7: After reset, done_o and pass_o are low and the signature holds the seed 0xACE1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear_i | input | 1 | Session start: reseed signature, drop verdict |
| resp_valid_i | input | 1 | Response word valid strobe |
| resp_data_i | input | 16 | Parallel response word |
| end_i | input | 1 | End-of-test strobe |
| golden_i | input | 16 | Expected signature |
| pass_o | output | 1 | Test verdict, high only for a finished matching session |
| done_o | output | 1 | Verdict taken |

## Verification
The assertions assume that clear_i, end_i and resp_valid_i are known in every cycle after reset. They also assume that golden_i only matters in the end cycle. The stimulus drives all three strobes one cycle at a time from a fixed offset after the clock edge and returns them to idle right after. The bench applies clear together with end and with valid, and end together with a word. It also uses gapped streams with noise on the data lines while valid is low, and post-done activity. Every session starts from a clear, so every sequence stays inside what the properties take for granted.

// File: rtl/sigchk_pkg.sv
package sigchk_pkg;
  localparam int          SIG_W_DEF = 16;
  localparam logic [15:0] POLY_DEF  = 16'h002D;
  localparam logic [15:0] SEED_DEF  = 16'hACE1;

  typedef struct packed {
    logic finished;
    logic match;
  } verdict_t;
endpackage

// File: rtl/sigchk_misr.sv
module sigchk_misr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'h002D,
  parameter logic [W-1:0]   SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sig_o
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] sig_q;
  logic [W-1:0] sig_d;
  logic [W-1:0] fb_mask;
  logic         sig_en;

  always_comb begin
    fb_mask = sig_q[W-1] ? POLY : ZERO;
    sig_en  = clear_i | valid_i;
    if (clear_i) sig_d = SEED;
    else         sig_d = {sig_q[W-2:0], 1'b0} ^ fb_mask ^ data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sig_q <= SEED;
    else if (sig_en) sig_q <= sig_d;
  end

  assign sig_o = sig_q;

  AST_CLEAR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (sig_o == SEED)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !valid_i) |=> $stable(sig_o)); // R3
endmodule

// File: rtl/sigchk_judge.sv
module sigchk_judge
  import sigchk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         end_i,
  input  logic [W-1:0] sig_i,
  input  logic [W-1:0] golden_i,
  output logic         done_o,
  output logic         pass_o
);
  verdict_t v_q;
  verdict_t v_d;
  logic     v_en;

  always_comb begin
    v_en = clear_i | (end_i & ~v_q.finished);
    if (clear_i) begin
      v_d.finished = 1'b0;
      v_d.match    = 1'b0;
    end else begin
      v_d.finished = 1'b1;
      v_d.match    = (sig_i == golden_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    v_q <= '0;
    else if (v_en) v_q <= v_d;
  end

  assign done_o = v_q.finished;
  assign pass_o = v_q.finished & v_q.match;

  AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && !clear_i) |=> done_o); // R4
  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !clear_i) |=> (done_o && $stable(pass_o))); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!done_o && !pass_o)); // R2
endmodule

// File: rtl/sig_check_unit.sv
module sig_check_unit
  import sigchk_pkg::*;
#(
  parameter int                 SIG_W = SIG_W_DEF,
  parameter logic [SIG_W-1:0]   POLY  = POLY_DEF,
  parameter logic [SIG_W-1:0]   SEED  = SEED_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             resp_valid_i,
  input  logic [SIG_W-1:0] resp_data_i,
  input  logic             end_i,
  input  logic [SIG_W-1:0] golden_i,
  output logic             pass_o,
  output logic             done_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  logic [SIG_W-1:0]       sig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  sigchk_misr #(.W(SIG_W), .POLY(POLY), .SEED(SEED)) u_misr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear_i (clear_i),
    .valid_i (resp_valid_i),
    .data_i  (resp_data_i),
    .sig_o   (sig)
  );

  sigchk_judge #(.W(SIG_W)) u_judge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear_i  (clear_i),
    .end_i    (end_i),
    .sig_i    (sig),
    .golden_i (golden_i),
    .done_o   (done_o),
    .pass_o   (pass_o)
  );

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !done_o |-> !pass_o); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_int_n |-> (!done_o && !pass_o)); // R7
endmodule

// File: tb/sim_sig_check_unit.sv
`timescale 1ns/1ps
module sim_sig_check_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_i = 1'b0;
  logic        resp_valid_i = 1'b0;
  logic [15:0] resp_data_i = '0;
  logic        end_i = 1'b0;
  logic [15:0] golden_i = '0;
  logic        pass_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic [15:0] m_sig;
  logic        m_done;
  logic        m_pass;

  always #2.5 clk = ~clk;

  sig_check_unit u0 (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .resp_valid_i(resp_valid_i),
    .resp_data_i(resp_data_i), .end_i(end_i), .golden_i(golden_i),
    .pass_o(pass_o), .done_o(done_o)
  );

  function automatic logic [15:0] fold(input logic [15:0] s, input logic [15:0] d);
    int v;
    v = (int'(s) * 2) % 65536;
    if (s >= 16'h8000) v = v ^ 'h2D;
    v = v ^ int'(d);
    return v[15:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sig <= 16'hACE1; m_done <= 1'b0; m_pass <= 1'b0;
    end else if (clear_i) begin
      m_sig <= 16'hACE1; m_done <= 1'b0; m_pass <= 1'b0;
    end else begin
      if (resp_valid_i) m_sig <= fold(m_sig, resp_data_i);
      if (end_i && !m_done) begin
        m_done <= 1'b1;
        m_pass <= (m_sig == golden_i);
      end
    end
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (done_o !== m_done || pass_o !== m_pass) begin
        errors++;
        $display("FAIL R4/R5/R6 cycle model: done=%b pass=%b expected done=%b pass=%b",
                 done_o, pass_o, m_done, m_pass);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic v, input logic [15:0] d,
                      input logic e, input logic [15:0] g);
    clear_i = c; resp_valid_i = v; resp_data_i = d; end_i = e; golden_i = g;
    @(posedge clk); #1;
    clear_i = 0; resp_valid_i = 0; end_i = 0;
    resp_data_i = 16'($urandom);
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) idle();
    chk("R7 done after reset", done_o, 1'b0);
    chk("R7 pass after reset", pass_o, 1'b0);
    // R7: seed visible with no words
    step(0, 0, 0, 1, 16'hACE1);
    chk("R7 seed compare done", done_o, 1'b1);
    chk("R7 seed compare pass", pass_o, 1'b1);

    // R2: clear together with end keeps done low
    step(1, 0, 0, 1, 16'hACE1);
    chk("R2 clear wins over end done", done_o, 1'b0);
    chk("R2 clear drops pass", pass_o, 1'b0);
    // R2: clear together with valid leaves the seed
    step(1, 1, 16'h1234, 0, 0);
    step(0, 0, 0, 1, 16'hACE1);
    chk("R2 clear wins over valid", pass_o, 1'b1);

    // R1: stream of words, matching golden
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) begin
      step(0, 1, 16'(16'hF00F ^ (i * 16'h1111)), 0, 0);
      chk("R6 pass low while running", pass_o, 1'b0);
    end
    step(0, 0, 0, 1, m_sig);
    chk("R1 stream signature match", pass_o, 1'b1);

    // R4: mismatch by one bit
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 1, 16'hFFFF, 0, 0);
    step(0, 0, 0, 1, m_sig ^ 16'h0001);
    chk("R4 mismatch done", done_o, 1'b1);
    chk("R4 mismatch fails", pass_o, 1'b0);

    // R3: gapped stream with noise on data while valid low
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) begin
      step(0, 1, 16'($urandom), 0, 0);
      step(0, 0, 16'($urandom), 0, 0);
      step(0, 0, 16'($urandom), 0, 0);
    end
    step(0, 0, 0, 1, m_sig);
    chk("R3 gaps ignored", pass_o, 1'b1);

    // R4: word in the end cycle is not part of the compare
    step(1, 0, 0, 0, 0);
    step(0, 1, 16'h0BAD, 0, 0);
    step(0, 1, 16'h5A5A, 1, m_sig);
    chk("R4 end-cycle word excluded", pass_o, 1'b1);

    // R5: activity after done leaves verdict alone
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 16'($urandom), 1, 16'($urandom));
      chk("R5 done held", done_o, 1'b1);
      chk("R5 pass held", pass_o, 1'b1);
    end
    // R5: failing verdict is held too
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 16'h0000);
    step(0, 0, 0, 1, 16'hACE1);
    chk("R5 fail held against later match", pass_o, 1'b0);

    // R1: long random stream
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 200; i++) step(0, ($urandom % 4) != 0, 16'($urandom), 0, 0);
    step(0, 0, 0, 1, m_sig);
    chk("R1 long stream match", pass_o, 1'b1);

    step(1, 0, 0, 0, 0);
    chk("R6 pass low after clear", pass_o, 1'b0);
    repeat (3) idle();
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule